// File: doc/BRIEF.md
# Branch-Aware Instruction Fetch Controller

This block is the front end of a five-stage in-order pipeline. It owns the program counter, presents a word address to an instruction memory that answers within the same cycle, and loads the returned word, its address and a valid flag into the fetch/decode pipeline register. The decode stage reports each conditional branch back through a small resolution interface: a branch flag, a taken flag and a target address. These are valid in the cycle the branch occupies decode.

A static parameter fixes how control hazards are handled. In freeze mode every branch costs one bubble. In not-taken mode fetch runs ahead sequentially, and a taken branch squashes the one wrong-path word. In delay-slot mode the word after a branch always executes and a taken branch redirects after it, so no cycle is lost. A stall input from later stages freezes the whole front end. A redirect or squash that is pending takes effect only on a cycle in which decode advances.

Top module: `bfetch_top`

## Requirements
- R1: While reset is asserted, the memory address equals the RESET_VEC parameter and the fetch/decode valid flag is 0.
- R2: A word whose two most significant bits are 2'b11 is a branch; for such a word bit 29 is taken in the test program and bits 15:0 are the target. The resolution inputs are honoured only while the fetch/decode register holds a valid entry.
- R3: While stall_i is 1, the memory address and every fetch/decode field keep their values across the clock edge, and any redirect or squash waits for the first cycle with stall_i at 0.
- R4: Freeze policy: the slot after a branch is always a bubble. Fetch then resumes at the target when the branch is taken, or at the branch address plus one when it is not, so each branch costs exactly one cycle.
- R5: Not-taken policy: an untaken branch is followed directly by the valid word at its address plus one, with no bubble.
- R6: Not-taken policy: when a branch resolves taken, the word fetched in that cycle enters the register with valid 0, and the next fetch address is the target. This gives exactly one idle slot.
- R7: Delay-slot policy: the word after a branch always enters valid. A taken branch loads the target into the address in that same edge, so no slot is ever a bubble.
- R8: With no redirect, each advancing cycle captures the current word and address with valid 1 and increments the address by one. Only valid entries follow the program's architectural path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Hold request from later stages |
| imem_addr_o | output | ADDR_W | Word address to instruction memory |
| imem_data_i | input | INSTR_W | Instruction word returned in the same cycle |
| id_branch_i | input | 1 | Decode holds a branch this cycle |
| id_taken_i | input | 1 | That branch is taken |
| id_target_i | input | ADDR_W | Branch target address |
| ifid_valid_o | output | 1 | Fetch/decode entry is real work |
| ifid_instr_o | output | INSTR_W | Fetch/decode instruction word |
| ifid_pc_o | output | ADDR_W | Address the entry was fetched from |

## Verification
The assertions assume that the decode stage raises the branch flag only for a valid branch word held in the fetch/decode register. They also assume that the resolution inputs stay steady while that entry is held by a stall. The bench meets both assumptions because its decode model is a pure function of the registered fetch/decode outputs. Its test program never places a branch directly after another branch, so a delay slot never contains a branch. Stall patterns are applied on fixed cycle residues, which lets holds land on fetches, on pending bubbles and on taken resolutions alike.

// File: rtl/bfetch_pkg.sv
package bfetch_pkg;
  typedef enum logic [1:0] {
    POL_FREEZE     = 2'd0,
    POL_NOT_TAKEN  = 2'd1,
    POL_DELAY_SLOT = 2'd2
  } policy_e;

  localparam logic [1:0] BR_TAG = 2'b11;
endpackage

// File: rtl/bfetch_pc.sv
module bfetch_pc #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              hold_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_VEC;
    end else if (adv_i) begin
      if (redirect_i)   pc_q <= target_i;
      else if (!hold_i) pc_q <= pc_q + STEP;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/bfetch_hazard.sv
module bfetch_hazard
  import bfetch_pkg::*;
#(
  parameter policy_e POLICY = POL_NOT_TAKEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic fetch_br_i,
  input  logic res_valid_i,
  input  logic res_taken_i,
  output logic redirect_o,
  output logic bubble_o,
  output logic hold_o
);
  // freeze only: a branch sits in IF/ID, next slot must be a bubble
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (adv_i) pend_q <= (POLICY == POL_FREEZE) && !pend_q && fetch_br_i;
  end

  logic take;
  assign take = res_valid_i && res_taken_i;

  always_comb begin
    unique case (POLICY)
      POL_FREEZE: begin
        redirect_o = pend_q && take;
        bubble_o   = pend_q;
        hold_o     = pend_q;
      end
      POL_NOT_TAKEN: begin
        redirect_o = take;
        bubble_o   = take;
        hold_o     = 1'b0;
      end
      default: begin
        redirect_o = take;
        bubble_o   = 1'b0;
        hold_o     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bfetch_ifid.sv
module bfetch_ifid #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic               bubble_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic               valid_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic [ADDR_W-1:0]  pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      instr_o <= '0;
      pc_o    <= '0;
    end else if (adv_i) begin
      valid_o <= !bubble_i;
      instr_o <= instr_i;
      pc_o    <= pc_i;
    end
  end
endmodule

// File: rtl/bfetch_top.sv
module bfetch_top
  import bfetch_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       INSTR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter policy_e           POLICY    = POL_NOT_TAKEN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  input  logic               id_branch_i,
  input  logic               id_taken_i,
  input  logic [ADDR_W-1:0]  id_target_i,
  output logic               ifid_valid_o,
  output logic [INSTR_W-1:0] ifid_instr_o,
  output logic [ADDR_W-1:0]  ifid_pc_o
);
  localparam int unsigned TAG_W = $bits(BR_TAG);

  logic adv, fetch_br, res_valid, redirect, bubble, hold;
  logic [ADDR_W-1:0] pc;

  assign adv       = !stall_i;
  assign fetch_br  = imem_data_i[INSTR_W-1 -: TAG_W] == BR_TAG;
  assign res_valid = ifid_valid_o && id_branch_i;

  bfetch_hazard #(.POLICY(POLICY)) u_haz (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .fetch_br_i (fetch_br),
    .res_valid_i(res_valid),
    .res_taken_i(id_taken_i),
    .redirect_o (redirect),
    .bubble_o   (bubble),
    .hold_o     (hold)
  );

  bfetch_pc #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .hold_i    (hold),
    .redirect_i(redirect),
    .target_i  (id_target_i),
    .pc_o      (pc)
  );

  bfetch_ifid #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_ifid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .bubble_i(bubble),
    .instr_i (imem_data_i),
    .pc_i    (pc),
    .valid_o (ifid_valid_o),
    .instr_o (ifid_instr_o),
    .pc_o    (ifid_pc_o)
  );

  assign imem_addr_o = pc;
endmodule

// File: rtl/bfetch_chk.sv
module bfetch_chk
  import bfetch_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned INSTR_W = 32,
  parameter policy_e     POLICY  = POL_NOT_TAKEN
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stall_i,
  input logic [ADDR_W-1:0]  imem_addr_o,
  input logic [INSTR_W-1:0] imem_data_i,
  input logic               id_branch_i,
  input logic               id_taken_i,
  input logic [ADDR_W-1:0]  id_target_i,
  input logic               ifid_valid_o,
  input logic [INSTR_W-1:0] ifid_instr_o,
  input logic [ADDR_W-1:0]  ifid_pc_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic take_now;
  assign take_now = ifid_valid_o && id_branch_i && id_taken_i && !stall_i;

  // R2: decode reports a branch only for a valid branch word
  a_r2_resolve_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_branch_i |-> ifid_valid_o && (ifid_instr_o[INSTR_W-1 -: 2] == BR_TAG));

  a_r3_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(imem_addr_o) && $stable(ifid_valid_o)
             && $stable(ifid_pc_o) && $stable(ifid_instr_o));

  generate
    if (POLICY == POL_FREEZE) begin : g_frz
      a_r4_one_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ifid_valid_o && id_branch_i && !stall_i) |=> !ifid_valid_o
          && (imem_addr_o == ($past(id_taken_i) ? $past(id_target_i) : $past(ifid_pc_o) + ONE)));
    end else begin : g_seq
      a_r8_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stall_i && !(ifid_valid_o && id_branch_i && id_taken_i)) |=> ifid_valid_o
          && (ifid_instr_o == $past(imem_data_i)) && (ifid_pc_o == $past(imem_addr_o))
          && (imem_addr_o == $past(imem_addr_o) + ONE));
    end
    if (POLICY == POL_NOT_TAKEN) begin : g_pnt
      a_r5_untaken_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ifid_valid_o && id_branch_i && !id_taken_i && !stall_i) |=> ifid_valid_o
          && (ifid_pc_o == $past(ifid_pc_o) + ONE));
      a_r6_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_now |=> !ifid_valid_o && (imem_addr_o == $past(id_target_i)));
    end
    if (POLICY == POL_DELAY_SLOT) begin : g_dly
      a_r7_slot_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_now |=> ifid_valid_o && (ifid_pc_o == $past(imem_addr_o))
          && (imem_addr_o == $past(id_target_i)));
    end
  endgenerate
endmodule

bind bfetch_top bfetch_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .POLICY(POLICY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_i     (stall_i),
  .imem_addr_o (imem_addr_o),
  .imem_data_i (imem_data_i),
  .id_branch_i (id_branch_i),
  .id_taken_i  (id_taken_i),
  .id_target_i (id_target_i),
  .ifid_valid_o(ifid_valid_o),
  .ifid_instr_o(ifid_instr_o),
  .ifid_pc_o   (ifid_pc_o)
);

// File: tb/sim_bfetch_top.sv
`timescale 1ns/1ps
module sim_bfetch_top;
  import bfetch_pkg::*;

  localparam int AW = 16;
  localparam int IW = 32;
  localparam int ND = 3;
  localparam logic [AW-1:0] RV = 16'h0004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] addr_w [ND];
  logic [IW-1:0] data_w [ND];
  logic          br_w   [ND];
  logic          tk_w   [ND];
  logic [AW-1:0] tg_w   [ND];
  logic          vld_w  [ND];
  logic [IW-1:0] ins_w  [ND];
  logic [AW-1:0] pc_w   [ND];

  // program: branch where addr%5==3, taken when (addr/5) even, target addr+7
  function automatic logic [IW-1:0] prog_word(input logic [AW-1:0] addr);
    int a;
    a = int'(addr[5:0]);
    if (a % 5 == 3) return {2'b11, ((a / 5) % 2 == 0), 13'b0, 16'(a) + 16'd7};
    return {16'h0, addr};
  endfunction

  for (genvar g = 0; g < ND; g++) begin : g_dut
    localparam policy_e P = (g == 0) ? POL_FREEZE : (g == 1) ? POL_NOT_TAKEN : POL_DELAY_SLOT;
    assign data_w[g] = prog_word(addr_w[g]);
    assign br_w[g]   = vld_w[g] && (ins_w[g][31:30] == 2'b11);
    assign tk_w[g]   = br_w[g] && ins_w[g][29];
    assign tg_w[g]   = ins_w[g][15:0];
    bfetch_top #(.ADDR_W(AW), .INSTR_W(IW), .RESET_VEC(RV), .POLICY(P)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
      .imem_addr_o(addr_w[g]), .imem_data_i(data_w[g]),
      .id_branch_i(br_w[g]), .id_taken_i(tk_w[g]), .id_target_i(tg_w[g]),
      .ifid_valid_o(vld_w[g]), .ifid_instr_o(ins_w[g]), .ifid_pc_o(pc_w[g])
    );
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int d);
    if (d == 0) return "R4";
    if (d == 1) return "R5/R6";
    return "R7";
  endfunction

  task automatic run(input int nval, input bit use_stall);
    logic [AW-1:0] m_pc [ND];
    logic [AW-1:0] m_tgt[ND];
    bit            m_pnd[ND];
    bit            done [ND];
    int nv[ND], ns[ND], ex[ND];
    logic          p_v [ND];
    logic [IW-1:0] p_i [ND];
    logic [AW-1:0] p_p [ND];
    logic [AW-1:0] p_a [ND];
    int cyc;
    bit st;
    logic [IW-1:0] x;
    bit isbr, istk;
    rst_n = 1'b0;
    stall = 1'b0;
    for (int d = 0; d < ND; d++) begin
      m_pc[d] = RV; m_tgt[d] = '0; m_pnd[d] = 0; done[d] = 0;
      nv[d] = 0; ns[d] = 0; ex[d] = nval;
    end
    repeat (2) @(negedge clk);
    for (int d = 0; d < ND; d++) begin
      check(addr_w[d] == RV, "R1", "reset address", addr_w[d], RV);
      check(vld_w[d] == 1'b0, "R1", "reset valid", vld_w[d], 0);
    end
    rst_n = 1'b1;
    cyc = 0;
    while (!(done[0] && done[1] && done[2]) && cyc < 5000) begin
      st = use_stall && ((cyc % 7 == 3) || (cyc % 11 == 5));
      stall = st;
      for (int d = 0; d < ND; d++) begin
        p_v[d] = vld_w[d]; p_i[d] = ins_w[d]; p_p[d] = pc_w[d]; p_a[d] = addr_w[d];
      end
      @(negedge clk);
      cyc++;
      for (int d = 0; d < ND; d++) begin
        if (done[d]) continue;
        if (st) begin
          check(vld_w[d] == p_v[d] && ins_w[d] == p_i[d] && pc_w[d] == p_p[d]
                && addr_w[d] == p_a[d], "R3", "stall hold", addr_w[d], p_a[d]);
        end else begin
          ns[d]++;
          if (vld_w[d]) begin
            x = prog_word(m_pc[d]);
            check(pc_w[d] == m_pc[d], "R8", "entry address", pc_w[d], m_pc[d]);
            check(ins_w[d] == x, tag_of(d), "entry word", ins_w[d], x);
            isbr = x[31:30] == 2'b11;
            istk = isbr && x[29];
            if (nv[d] < nval - 1) begin
              if (d == 0 && isbr) ex[d]++;
              if (d == 1 && istk) ex[d]++;
            end
            if (d == 2) begin
              if (m_pnd[d]) begin m_pc[d] = m_tgt[d]; m_pnd[d] = 0; end
              else begin
                if (istk) begin m_pnd[d] = 1; m_tgt[d] = x[15:0]; end
                m_pc[d] = m_pc[d] + 16'd1;
              end
            end else begin
              m_pc[d] = istk ? x[15:0] : m_pc[d] + 16'd1;
            end
            nv[d]++;
            if (nv[d] == nval) begin
              done[d] = 1;
              check(ns[d] == ex[d], tag_of(d), "slot count", ns[d], ex[d]);
            end
          end
        end
      end
    end
    if (cyc >= 5000) check(1'b0, "R8", "run watchdog", cyc, 5000);
    stall = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "R8", "global watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    run(60, 1'b0);
    run(60, 1'b1);
    run(25, 1'b1);
    run(40, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule